// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

A 16-bit programmable down-counter with a small register interface. Software places a start value in the counter through the Load register. The counter then steps down by one on each count tick from one of two rate inputs, a fast one or a slow one, chosen by a bit in the Control register. The live count can be read back at any time without disturbing it.

When the counter steps below zero it underflows. In free-running mode it wraps to 0xFFFF and keeps counting. In periodic mode it reloads the last value written to Load, so the block can act as a programmable-rate source. Every underflow raises a level interrupt. The interrupt stays high until software writes the Clear register.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the count, the stored load value, the Control bits and the interrupt are all zero.
- R2: A write to offset 0 (Load) puts the written value into both the counter and the stored load value at that clock edge. Reading offset 0 returns the stored load value and reading offset 1 (Value) returns the count.
- R3: While the timer is enabled, each selected tick lowers the count by one. A tick that arrives in the same cycle as a Load write is ignored, so the first decrement comes from the first tick after the write.
- R4: With Control bit 1 at 0 (free-running mode), a tick at count 0 makes the count 0xFFFF.
- R5: With Control bit 1 at 1 (periodic mode), a tick at count 0 makes the count equal to the stored load value.
- R6: Control bit 2 chooses the tick source: 0 selects tickFast and 1 selects tickSlow. Pulses on the input that is not selected have no effect on the count.
- R7: While Control bit 0 (enable) is 0, the count holds its value whatever the tick inputs do.
- R8: The interrupt output rises on the same clock edge at which an underflow changes the count.
- R9: A write of any data to offset 3 (Clear) lowers the interrupt. If an underflow happens in the same cycle, the interrupt stays high.
- R10: Reading offset 1 never changes the count, and a write to offset 1 is ignored.
- R11: Reading offset 2 returns Control bits 2:0 as last written, with the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register offset: 0 Load, 1 Value, 2 Control, 3 Clear |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for the addressed register (combinational) |
| tickFast | input | 1 | One-cycle count pulse, fast rate |
| tickSlow | input | 1 | One-cycle count pulse, slow rate |
| irq | output | 1 | Underflow interrupt, held until cleared |

## Verification
The hardest case to reach is a Clear write that lands in the same cycle as an underflow. The counter must be at zero with the selected tick pulsing exactly when software writes Clear. A directed sequence sets this up by loading 1 in periodic mode and stepping it with single ticks, so the underflow cycle is known in advance. The bench also drives a Load write and a tick together to check that the write wins. A seeded random phase then mixes writes to all four offsets with pulses on both tick inputs, so underflows, clears and mode switches meet in arbitrary orders.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LOAD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_VALUE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR = 2'd3;

  localparam int unsigned CTRL_W      = 3;
  localparam int unsigned BIT_ENABLE  = 0;
  localparam int unsigned BIT_PERIOD  = 1;
  localparam int unsigned BIT_SLOWSEL = 2;

  typedef struct packed {
    logic loadNow;
    logic stepNow;
    logic periodic;
  } tmrStrobes_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] loadReg,
  output logic             cntZero
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] countNext;
  logic [WIDTH-1:0] wrapVal;

  assign cntZero = (count == '0);
  assign wrapVal = strobes.periodic ? loadReg : MAX_VAL;

  always_comb begin
    countNext = count;
    if (strobes.loadNow) begin
      countNext = wrData;
    end else if (strobes.stepNow) begin
      countNext = cntZero ? wrapVal : count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      loadReg <= '0;
    end else begin
      count <= countNext;
      if (strobes.loadNow) loadReg <= wrData;
    end
  end

  // R2: a load lands in the counter at the next edge
  a_r2_load_now: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNow |=> (count == $past(wrData)));
  // R3: a normal step lowers the count by exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && !strobes.loadNow && !cntZero) |=> (count == $past(count) - 1'b1));
  // R4: free-running underflow wraps to all ones
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && !strobes.loadNow && cntZero && !strobes.periodic) |=> (count == MAX_VAL));
  // R5: periodic underflow reloads the stored value
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepNow && !strobes.loadNow && cntZero && strobes.periodic) |=> (count == $past(loadReg)));
  // R7: no strobe, no change
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.stepNow && !strobes.loadNow) |=> $stable(count));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic             tickFast,
  input  logic             tickSlow,
  input  logic [WIDTH-1:0] cntValue,
  input  logic [WIDTH-1:0] loadValue,
  input  logic             cntZero,
  output tmrStrobes_t      strobes,
  output logic             irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic wrLoad, wrCtrl, wrClear;
  logic tickSel, underflow;

  assign wrLoad  = busWrEn && (busAddr == ADDR_LOAD);
  assign wrCtrl  = busWrEn && (busAddr == ADDR_CTRL);
  assign wrClear = busWrEn && (busAddr == ADDR_CLEAR);

  assign tickSel = ctrlReg[BIT_SLOWSEL] ? tickSlow : tickFast;

  assign strobes.loadNow  = wrLoad;
  assign strobes.stepNow  = ctrlReg[BIT_ENABLE] && tickSel && !wrLoad;
  assign strobes.periodic = ctrlReg[BIT_PERIOD];

  assign underflow = strobes.stepNow && cntZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      irq     <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= busWrData[CTRL_W-1:0];
      if (underflow)    irq <= 1'b1;
      else if (wrClear) irq <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_LOAD:  busRdData = loadValue;
      ADDR_VALUE: busRdData = cntValue;
      ADDR_CTRL:  busRdData = {{(WIDTH-CTRL_W){1'b0}}, ctrlReg};
      default:    busRdData = '0;
    endcase
  end

  // R8: underflow raises the interrupt at the next edge
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> irq);
  // R9: a clear without a competing underflow drops the interrupt
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrClear && !underflow) |=> !irq);
  // R9: the interrupt only rises through an underflow
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(underflow));
  // R7: a disabled timer issues no steps
  a_r7_no_step: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[BIT_ENABLE] |-> !strobes.stepNow);
  // R11: control bits follow the last write
  a_r11_ctrl: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> (ctrlReg == $past(busWrData[CTRL_W-1:0])));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import timer_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  parameter int unsigned AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic             tickFast,
  input  logic             tickSlow,
  output logic             irq
);
  tmrStrobes_t      strobes;
  logic [WIDTH-1:0] count;
  logic [WIDTH-1:0] loadReg;
  logic             cntZero;

  timer_ctrl #(.WIDTH(WIDTH), .AW(AW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .tickFast  (tickFast),
    .tickSlow  (tickSlow),
    .cntValue  (count),
    .loadValue (loadReg),
    .cntZero   (cntZero),
    .strobes   (strobes),
    .irq       (irq)
  );

  timer_datapath #(.WIDTH(WIDTH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (busWrData),
    .count   (count),
    .loadReg (loadReg),
    .cntZero (cntZero)
  );
endmodule

// File: tb/sim_dual_mode_timer.sv
module sim_dual_mode_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = 2'd1;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        tickFast = 1'b0;
  logic        tickSlow = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] mCount = '0;
  logic [15:0] mLoad  = '0;
  logic [2:0]  mCtrl  = '0;
  logic        mIrq   = 1'b0;

  always #4 clk = ~clk;

  dual_mode_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .tickFast(tickFast), .tickSlow(tickSlow), .irq(irq)
  );

  function automatic logic modelStep(input logic [2:0] c, input logic we,
                                     input logic [1:0] a, input logic tf, input logic ts);
    logic t;
    t = c[2] ? ts : tf;
    return c[0] && t && !(we && a == 2'd0);
  endfunction

  function automatic logic [15:0] modelNext(input logic [15:0] cnt, input logic [15:0] ld,
                                            input logic [2:0] c, input logic we, input logic [1:0] a,
                                            input logic [15:0] d, input logic st);
    if (we && a == 2'd0) return d;
    if (!st) return cnt;
    if (cnt == 16'd0) return c[1] ? ld : 16'hFFFF;
    return cnt - 16'd1;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
    busAddr = 2'd1;
  endtask

  task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic tf, input logic ts, input string tag);
    logic st, uf;
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; tickFast = tf; tickSlow = ts;
    @(posedge clk);
    #1;
    st = modelStep(mCtrl, we, a, tf, ts);
    uf = st && (mCount == 16'd0);
    mCount = modelNext(mCount, mLoad, mCtrl, we, a, d, st);
    if (we && a == 2'd0) mLoad = d;
    if (we && a == 2'd2) mCtrl = d[2:0];
    if (uf) mIrq = 1'b1;
    else if (we && a == 2'd3) mIrq = 1'b0;
    busWrEn = 1'b0; tickFast = 1'b0; tickSlow = 1'b0; busAddr = 2'd1;
    #1;
    chk({tag, " count"}, busRdData, mCount);
    chk({tag, " irq"}, {15'd0, irq}, {15'd0, mIrq});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    rd(2'd0, 16'd0, "R1 load");
    rd(2'd1, 16'd0, "R1 value");
    rd(2'd2, 16'd0, "R1 ctrl");
    chk("R1 irq", {15'd0, irq}, 16'd0);

    // enable, fast source, free-running
    cyc(1, 2'd2, 16'h0001, 0, 0, "R11 ctrl write");
    // R3: tick with load write is ignored; R2 load lands at once
    cyc(1, 2'd0, 16'd5, 1, 0, "R3 R2 load with tick");
    chk("R2 value", busRdData, 16'd5);
    rd(2'd0, 16'd5, "R2 load readback");
    for (int i = 0; i < 3; i++) cyc(0, 2'd1, 0, 1, 0, "R3 step");
    chk("R3 after 3 ticks", busRdData, 16'd2);
    // R6: slow pulses ignored while fast selected
    for (int i = 0; i < 4; i++) cyc(0, 2'd1, 0, 0, 1, "R6 unselected");
    chk("R6 held", busRdData, 16'd2);
    cyc(0, 2'd1, 0, 1, 0, "R3 step");
    cyc(0, 2'd1, 0, 1, 0, "R3 step to zero");
    chk("R8 no irq at zero", {15'd0, irq}, 16'd0);
    // R4 wrap and R8 interrupt
    cyc(0, 2'd1, 0, 1, 0, "R4 wrap");
    chk("R4 wrap value", busRdData, 16'hFFFF);
    chk("R8 irq set", {15'd0, irq}, 16'd1);
    // R9 clear
    cyc(1, 2'd3, 16'h5A5A, 0, 0, "R9 clear");
    chk("R9 irq low", {15'd0, irq}, 16'd0);
    // R10 value write ignored
    cyc(1, 2'd1, 16'h1234, 0, 0, "R10 value write");
    chk("R10 unchanged", busRdData, 16'hFFFF);
    // periodic, slow source
    cyc(1, 2'd0, 16'd1, 0, 0, "R2 load 1");
    cyc(1, 2'd2, 16'hFFFF, 0, 0, "R11 ctrl all");
    rd(2'd2, 16'd7, "R11 ctrl readback");
    cyc(0, 2'd1, 0, 1, 0, "R6 fast ignored");
    chk("R6 fast ignored", busRdData, 16'd1);
    cyc(0, 2'd1, 0, 0, 1, "R5 step");
    cyc(0, 2'd1, 0, 0, 1, "R5 reload");
    chk("R5 reloaded", busRdData, 16'd1);
    chk("R8 irq periodic", {15'd0, irq}, 16'd1);
    // R9: clear wins without underflow, loses with one
    cyc(1, 2'd3, 0, 0, 1, "R9 clear step");
    chk("R9 cleared", {15'd0, irq}, 16'd0);
    cyc(1, 2'd3, 0, 0, 1, "R9 clear with underflow");
    chk("R9 underflow wins", {15'd0, irq}, 16'd1);
    // R7 disable holds
    cyc(1, 2'd2, 16'h0006, 0, 0, "R7 disable");
    for (int i = 0; i < 5; i++) cyc(0, 2'd1, 0, 1, 1, "R7 hold");
    chk("R7 held", busRdData, 16'd1);
    rd(2'd2, 16'd6, "R11 ctrl 6");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic we;
      logic [1:0] a;
      logic [15:0] d;
      r = $urandom();
      we = (r[3:0] == 4'd0);
      a = r[5:4];
      d = (r[7:6] == 2'd0) ? {14'd0, r[9:8]} : r[31:16];
      if (a == 2'd2) d = {13'd0, 1'b0, r[9], 1'b1} | {15'd0, r[10] & r[11]} ^ 16'd0;
      cyc(we, a, d, r[12], r[13], "R3 random");
      if (r[15:14] == 2'd0) begin
        rd(2'd0, mLoad, "R2 random load");
        rd(2'd2, {13'd0, mCtrl}, "R11 random ctrl");
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule